// File: doc/BRIEF.md
# Latency-Slotted Writeback Queue

This block schedules result writeback for a microcoded datapath that has an exposed pipeline and no interlocks. Each instruction that issues reports its result value and its latency, and the block parks that value in a seven-slot circular queue at a distance set by the latency. On every issue the value at the head of the queue is written into the register named by the destination field of the instruction issuing in that cycle. It is not written to the register named by the instruction that produced it. Microcode therefore places destination fields on the instruction that issues when a result matures.

The block decodes the instruction word and holds the 128-entry register file. Operand A and operand B are read from it combinationally. The block also holds the ring, its head pointer and the program counter. The operation units sit outside the block and supply only a result word and a latency. A no-operation instruction still drains the queue. The vector-output instruction ends the program and leaves both the queue and the program counter untouched.

Top module: `lat_slot_wbq`

## Requirements
- R1: The instruction word is split into operand A index in bits [24:18], operand B index in bits [17:11], opcode in bits [10:7] and destination index in bits [6:0]. `a_data_o` and `b_data_o` show the current register contents for A and B in the same cycle.
- R2: After reset all ring slots and all registers are zero, the head pointer is 0 and the program counter is 0.
- R3: When an instruction other than vector-output issues with a nonzero destination, the value at the head slot appears on the writeback port in that cycle and is in the register from the next cycle on.
- R4: A destination index of 0 writes no register. `wb_en_o` stays low and register contents are unchanged.
- R5: Each issue other than vector-output clears the head slot and advances the head pointer by one modulo 7, so it wraps from 6 to 0.
- R6: An issue with an opcode other than 0 (no-operation) and 7 (vector-output) stores its result in slot (old head + latency) modulo 7. That result is retired by the latency-th following queue-advancing issue. A latency of 0 is treated as 1.
- R7: Opcode 0 stores nothing but still retires and advances the queue.
- R8: Opcode 7 writes nothing, keeps the head pointer and the program counter, and raises `prog_end_o` for that cycle.
- R9: Every issue other than opcode 7 increments the program counter by one.
- R10: When two results are placed in the same slot, the later placement overwrites the earlier one.
- R11: A latency-7 result lands in the slot that its own issue just retired. It survives the clear and is retired seven advancing issues later.
- R12: In cycles without an issue, the ring, the head pointer, the program counter and the registers do not change, and no write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_i | input | 1 | An instruction issues this cycle |
| insn_i | input | 25 | Instruction word |
| res_i | input | 32 | Result of the issuing operation |
| res_lat_i | input | 3 | Latency of the issuing operation |
| a_data_o | output | 32 | Register contents at operand A index |
| b_data_o | output | 32 | Register contents at operand B index |
| wb_en_o | output | 1 | Register write this cycle |
| wb_addr_o | output | 7 | Register written |
| wb_data_o | output | 32 | Value written (head slot) |
| pc_o | output | 11 | Program counter |
| head_o | output | 3 | Ring head pointer |
| prog_end_o | output | 1 | Vector-output instruction issued this cycle |

## Verification
Retiring the head slot and inserting a new result can hit the same slot in one cycle. This happens when a latency-7 result is placed in the slot its own issue is clearing. It also happens when a second insertion lands on a slot already filled. The bench provokes both: it issues a latency-7 operation and then seven advancing issues, and it issues two operations whose latencies differ by one back to back. An independent slot model predicts which value reaches the destination of the retiring instruction, and the writeback port is compared against that prediction each cycle.

// File: rtl/wbq_pkg.sv
package wbq_pkg;
    localparam int RING_SLOTS = 7;
    localparam int PTR_W      = $clog2(RING_SLOTS);
    localparam int LAT_W      = 3;
    localparam int DATA_W     = 32;
    localparam int NUM_REGS   = 128;
    localparam int REG_IDX_W  = $clog2(NUM_REGS);
    localparam int OPC_W      = 4;
    localparam int INSN_W     = 3 * REG_IDX_W + OPC_W;
    localparam int PC_W       = 11;

    typedef logic [OPC_W-1:0]     opcode_t;
    typedef logic [PTR_W-1:0]     ptr_t;
    typedef logic [DATA_W-1:0]    word_t;
    typedef logic [REG_IDX_W-1:0] ridx_t;

    localparam opcode_t OPC_IDLE = 4'd0;
    localparam opcode_t OPC_VOUT = 4'd7;

    // Field order matches the word layout from MSB down.
    typedef struct packed {
        ridx_t   src_a;
        ridx_t   src_b;
        opcode_t opc;
        ridx_t   dst;
    } insn_t;

    // Modular add for ring positions; p < RING_SLOTS, d <= 7.
    function automatic ptr_t ring_add(input ptr_t p, input logic [LAT_W-1:0] d);
        logic [PTR_W:0] s;
        s = {1'b0, p} + {1'b0, d};
        if (s >= (PTR_W+1)'(RING_SLOTS)) s = s - (PTR_W+1)'(RING_SLOTS);
        return s[PTR_W-1:0];
    endfunction
endpackage

// File: rtl/wbq_decode.sv
module wbq_decode
    import wbq_pkg::*;
(
    input  logic [INSN_W-1:0] word_i,
    input  logic [LAT_W-1:0]  lat_i,
    output insn_t             fields_o,
    output logic              is_idle_o,
    output logic              is_vout_o,
    output logic [LAT_W-1:0]  eff_lat_o
);
    always_comb begin
        fields_o  = insn_t'(word_i);
        is_idle_o = (fields_o.opc == OPC_IDLE);
        is_vout_o = (fields_o.opc == OPC_VOUT);
        eff_lat_o = (lat_i == '0) ? LAT_W'(1) : lat_i;
    end
endmodule

// File: rtl/wbq_ring.sv
module wbq_ring
    import wbq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             adv_i,
    input  logic             ins_i,
    input  logic [LAT_W-1:0] ins_lat_i,
    input  word_t            ins_data_i,
    output ptr_t             head_o,
    output word_t            head_val_o
);
    ptr_t  head_q;
    ptr_t  tgt;
    ptr_t  head_nxt;
    word_t slot_q [RING_SLOTS];

    assign tgt      = ring_add(head_q, ins_lat_i);
    assign head_nxt = ring_add(head_q, LAT_W'(1));

    for (genvar g = 0; g < RING_SLOTS; g++) begin : g_slot
        logic clr_here;
        logic put_here;
        assign clr_here = adv_i && (head_q == ptr_t'(g));
        assign put_here = adv_i && ins_i && (tgt == ptr_t'(g));
        always_ff @(posedge clk) begin
            if (rst)           slot_q[g] <= '0;
            else if (put_here) slot_q[g] <= ins_data_i;
            else if (clr_here) slot_q[g] <= '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        head_q <= '0;
        else if (adv_i) head_q <= head_nxt;
    end

    assign head_o     = head_q;
    assign head_val_o = slot_q[head_q];
endmodule

// File: rtl/wbq_regfile.sv
module wbq_regfile
    import wbq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we_i,
    input  ridx_t waddr_i,
    input  word_t wdata_i,
    input  ridx_t raddr_a_i,
    input  ridx_t raddr_b_i,
    output word_t rdata_a_o,
    output word_t rdata_b_o
);
    word_t mem_q [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_a_o = mem_q[raddr_a_i];
    assign rdata_b_o = mem_q[raddr_b_i];
endmodule

// File: rtl/lat_slot_wbq.sv
module lat_slot_wbq
    import wbq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 issue_i,
    input  logic [INSN_W-1:0]    insn_i,
    input  logic [DATA_W-1:0]    res_i,
    input  logic [LAT_W-1:0]     res_lat_i,
    output logic [DATA_W-1:0]    a_data_o,
    output logic [DATA_W-1:0]    b_data_o,
    output logic                 wb_en_o,
    output logic [REG_IDX_W-1:0] wb_addr_o,
    output logic [DATA_W-1:0]    wb_data_o,
    output logic [PC_W-1:0]      pc_o,
    output logic [PTR_W-1:0]     head_o,
    output logic                 prog_end_o
);
    insn_t            dec;
    logic             is_idle;
    logic             is_vout;
    logic [LAT_W-1:0] eff_lat;
    logic             advance;
    word_t            head_val;
    logic [PC_W-1:0]  pc_q;

    wbq_decode u_dec (
        .word_i    (insn_i),
        .lat_i     (res_lat_i),
        .fields_o  (dec),
        .is_idle_o (is_idle),
        .is_vout_o (is_vout),
        .eff_lat_o (eff_lat)
    );

    assign advance = issue_i && !is_vout;

    wbq_ring u_ring (
        .clk        (clk),
        .rst        (rst),
        .adv_i      (advance),
        .ins_i      (!is_idle),
        .ins_lat_i  (eff_lat),
        .ins_data_i (res_i),
        .head_o     (head_o),
        .head_val_o (head_val)
    );

    assign wb_en_o   = advance && (dec.dst != '0);
    assign wb_addr_o = dec.dst;
    assign wb_data_o = head_val;

    wbq_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .we_i      (wb_en_o),
        .waddr_i   (dec.dst),
        .wdata_i   (head_val),
        .raddr_a_i (dec.src_a),
        .raddr_b_i (dec.src_b),
        .rdata_a_o (a_data_o),
        .rdata_b_o (b_data_o)
    );

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (advance) pc_q <= pc_q + 1'b1;
    end

    assign pc_o       = pc_q;
    assign prog_end_o = issue_i && is_vout;
endmodule

// File: rtl/wbq_chk.sv
module wbq_chk
    import wbq_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 issue_i,
    input logic [INSN_W-1:0]    insn_i,
    input logic                 wb_en_o,
    input logic [REG_IDX_W-1:0] wb_addr_o,
    input logic [PC_W-1:0]      pc_o,
    input logic [PTR_W-1:0]     head_o,
    input logic                 prog_end_o
);
    logic vout_now;
    assign vout_now = issue_i && (insn_i[10:7] == OPC_VOUT);

    AST_HEAD_RANGE: assert property (@(posedge clk) disable iff (rst)
        head_o < PTR_W'(RING_SLOTS)); // R5
    AST_HEAD_STEP: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !vout_now) |=> head_o == (($past(head_o) == PTR_W'(RING_SLOTS-1)) ? '0 : $past(head_o) + 1'b1)); // R5
    AST_VOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        vout_now |=> ($stable(head_o) && $stable(pc_o))); // R8
    AST_VOUT_NOWB: assert property (@(posedge clk) disable iff (rst)
        prog_end_o |-> !wb_en_o); // R8
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        (issue_i && !vout_now) |=> pc_o == $past(pc_o) + 1'b1); // R9
    AST_NO_ZERO_DST: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> wb_addr_o != '0); // R4
    AST_IDLE_STILL: assert property (@(posedge clk) disable iff (rst)
        !issue_i |=> ($stable(head_o) && $stable(pc_o))); // R12
    AST_IDLE_NOWB: assert property (@(posedge clk) disable iff (rst)
        !issue_i |-> !wb_en_o); // R12
endmodule

bind lat_slot_wbq wbq_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .issue_i    (issue_i),
    .insn_i     (insn_i),
    .wb_en_o    (wb_en_o),
    .wb_addr_o  (wb_addr_o),
    .pc_o       (pc_o),
    .head_o     (head_o),
    .prog_end_o (prog_end_o)
);

// File: tb/lat_slot_wbq_tb_top.sv
module lat_slot_wbq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        issue_i;
    logic [24:0] insn_i;
    logic [31:0] res_i;
    logic [2:0]  res_lat_i;
    logic [31:0] a_data_o, b_data_o, wb_data_o;
    logic        wb_en_o, prog_end_o;
    logic [6:0]  wb_addr_o;
    logic [10:0] pc_o;
    logic [2:0]  head_o;

    always #4 clk = ~clk;

    lat_slot_wbq dut_i (
        .clk(clk), .rst(rst), .issue_i(issue_i), .insn_i(insn_i),
        .res_i(res_i), .res_lat_i(res_lat_i),
        .a_data_o(a_data_o), .b_data_o(b_data_o),
        .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .pc_o(pc_o), .head_o(head_o), .prog_end_o(prog_end_o)
    );

    typedef struct {
        logic        en;
        logic [6:0]  addr;
        logic [31:0] data;
        logic        endp;
        logic [31:0] ad;
        logic [31:0] bd;
        logic [10:0] pc;
        logic [2:0]  head;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [31:0] m_slot [7];
    logic [31:0] m_reg [128];
    int          m_head;
    logic [10:0] m_pc;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 7; i++) m_slot[i] = '0;
        for (int i = 0; i < 128; i++) m_reg[i] = '0;
        m_head = 0;
        m_pc = '0;
    endtask

    task automatic issue(input logic [3:0] op, input logic [6:0] a, input logic [6:0] b,
                         input logic [6:0] d, input logic [31:0] res,
                         input logic [2:0] lat, input string tag);
        exp_t e;
        int   l;
        @(posedge clk); #1;
        issue_i   = 1'b1;
        insn_i    = {a, b, op, d};
        res_i     = res;
        res_lat_i = lat;
        e.ad   = m_reg[a];
        e.bd   = m_reg[b];
        e.pc   = m_pc;
        e.head = 3'(m_head);
        e.addr = d;
        if (op == 4'd7) begin
            e.en = 1'b0; e.endp = 1'b1; e.data = m_slot[m_head];
        end else begin
            e.endp = 1'b0;
            e.en   = (d != 0);
            e.data = m_slot[m_head];
            if (d != 0) m_reg[d] = m_slot[m_head];
            m_slot[m_head] = '0;
            if (op != 4'd0) begin
                l = (lat == 0) ? 1 : int'(lat);
                m_slot[(m_head + l) % 7] = res;
            end
            m_head = (m_head + 1) % 7;
            m_pc = m_pc + 1'b1;
        end
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk); #1;
            issue_i = 1'b0;
            insn_i  = {7'd3, 7'd4, 4'd1, 7'd8};
            @(negedge clk);
            chk("R12", "wb_en idle", 32'(wb_en_o), 32'd0);
            chk("R12", "pc idle", 32'(pc_o), 32'(m_pc));
            chk("R12", "head idle", 32'(head_o), 32'(m_head));
            chk("R12", "reg3 idle", a_data_o, m_reg[3]);
        end
    endtask

    // monitor: compare the design against the scoreboard on each issue
    always @(negedge clk) begin
        if (!rst && issue_i && exp_q.size() > 0) begin
            exp_t  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "wb_en", 32'(wb_en_o), 32'(e.en));
            if (e.en) begin
                chk(t, "wb_addr", 32'(wb_addr_o), 32'(e.addr));
                chk(t, "wb_data", wb_data_o, e.data);
            end
            chk("R8", "prog_end", 32'(prog_end_o), 32'(e.endp));
            chk("R1", "a_data", a_data_o, e.ad);
            chk("R1", "b_data", b_data_o, e.bd);
            chk("R9", "pc", 32'(pc_o), 32'(e.pc));
            chk("R5", "head", 32'(head_o), 32'(e.head));
        end
    end

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; issue_i = 1'b0; insn_i = '0; res_i = '0; res_lat_i = '0;
        model_reset();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        insn_i = {7'd20, 7'd21, 4'd0, 7'd0};
        @(negedge clk);
        chk("R2", "pc reset", 32'(pc_o), 32'd0);
        chk("R2", "head reset", 32'(head_o), 32'd0);
        chk("R2", "wb_en reset", 32'(wb_en_o), 32'd0);
        chk("R2", "reg20 reset", a_data_o, 32'd0);

        // basic latency placement and retirement into a later destination
        issue(4'd1, 7'd0, 7'd0, 7'd0, 32'h0000_00A1, 3'd2, "R6");
        issue(4'd0, 7'd0, 7'd0, 7'd9, 32'h0, 3'd0, "R7");
        issue(4'd0, 7'd0, 7'd0, 7'd10, 32'h0, 3'd0, "R3");
        issue(4'd0, 7'd10, 7'd9, 7'd0, 32'h0, 3'd0, "R1");

        // two insertions into one slot: the later wins
        issue(4'd2, 7'd0, 7'd0, 7'd0, 32'h0000_00B2, 3'd3, "R10");
        issue(4'd3, 7'd0, 7'd0, 7'd0, 32'h0000_00C3, 3'd2, "R10");
        issue(4'd0, 7'd0, 7'd0, 7'd0, 32'h0, 3'd0, "R10");
        issue(4'd0, 7'd11, 7'd0, 7'd11, 32'h0, 3'd0, "R10");
        issue(4'd0, 7'd11, 7'd0, 7'd0, 32'h0, 3'd0, "R10");

        // destination zero discards the retiring value
        issue(4'd1, 7'd0, 7'd0, 7'd0, 32'h0000_00D4, 3'd1, "R4");
        issue(4'd0, 7'd0, 7'd0, 7'd0, 32'h0, 3'd0, "R4");
        issue(4'd0, 7'd0, 7'd0, 7'd0, 32'h0, 3'd0, "R4");

        // latency 7 lands on the slot being cleared
        issue(4'd4, 7'd0, 7'd0, 7'd12, 32'h0000_00E5, 3'd7, "R11");
        for (int k = 0; k < 6; k++) issue(4'd0, 7'd0, 7'd0, 7'd0, 32'h0, 3'd0, "R11");
        issue(4'd0, 7'd0, 7'd0, 7'd13, 32'h0, 3'd0, "R11");
        issue(4'd0, 7'd13, 7'd12, 7'd0, 32'h0, 3'd0, "R11");

        // vector output freezes the queue and the counter
        issue(4'd1, 7'd0, 7'd0, 7'd0, 32'h0000_00F6, 3'd1, "R8");
        issue(4'd7, 7'd13, 7'd0, 7'd14, 32'h0000_0999, 3'd4, "R8");
        issue(4'd0, 7'd0, 7'd0, 7'd14, 32'h0, 3'd0, "R8");
        issue(4'd0, 7'd14, 7'd0, 7'd0, 32'h0, 3'd0, "R8");

        // latency 0 treated as 1
        issue(4'd5, 7'd0, 7'd0, 7'd0, 32'h0000_0077, 3'd0, "R6");
        issue(4'd0, 7'd0, 7'd0, 7'd15, 32'h0, 3'd0, "R6");
        issue(4'd0, 7'd15, 7'd14, 7'd0, 32'h0, 3'd0, "R6");

        // no issue: nothing moves
        idle(3);

        // long drain across head wrap, with mixed ops
        for (int k = 0; k < 10; k++)
            issue(4'((k % 3 == 0) ? 0 : 6), 7'(k), 7'(k + 1), 7'(16 + k),
                  32'h1000 + 32'(k), 3'(1 + (k % 7)), "R5");
        idle(1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule